// File: doc/BRIEF.md
# Four-Entry Register File with Captured ALU Operands

This block keeps a small bank of general-purpose registers and presents two of them to an arithmetic unit through a pair of operand registers. Any register can be loaded from a shared write-data bus. Each register has its own load strobe, and several registers may be loaded together. Two independent select codes each pick one register. The picked words are latched into operand register A and operand register B on the rising clock edge.

Read selection is built one bit column at a time. Each column has its own four-way AND-OR selector. All selectors on one side share one decoded select, so every bit of an operand comes from the same register. An asynchronous active-low clear zeroes the whole bank and both operand registers at boot.

Top module: `opnd_regfile`

## Requirements
- R1: While `clearN` is low, every general-purpose register and both operand outputs are zero. The clear acts at once, without waiting for a clock edge.
- R2: On a rising edge where `wrEn[r]` is 1, register r loads `wrData`. A register whose enable bit is 0 keeps its contents.
- R3: `selA` chooses the register for operand A. Code 0 (binary 00) picks R0, 1 picks R1, 2 picks R2 and 3 picks R3, and bit 0 of the code is its least significant bit. The picked word appears on `opndA` after the next rising edge.
- R4: `selB` chooses the register for operand B with the same code mapping. It works independently of `selA`, and the picked word appears on `opndB` after the next rising edge.
- R5: When `selA` and `selB` carry the same code, both operands capture the same register contents.
- R6: If a register is loaded on the same edge on which it is selected, the operand captures the contents it held before that edge.
- R7: The operand outputs change only on a rising edge. A select change between edges has no effect on `opndA` or `opndB` until the next edge.
- R8: When several bits of `wrEn` are 1 on one edge, every enabled register loads the same `wrData` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all storage |
| clearN | input | 1 | Asynchronous active-low clear of registers and operands |
| wrEn | input | 4 | Per-register load strobe; bit r loads register r |
| wrData | input | 4 | Shared write data |
| selA | input | 2 | Register code for operand A |
| selB | input | 2 | Register code for operand B |
| opndA | output | 4 | Captured operand A |
| opndB | output | 4 | Captured operand B |

## Verification
The bench builds the block with its default sizes: four registers, each 4 bits wide. At that size every select code on both sides can be visited with distinct contents in each register. This makes a wrong column wiring or a swapped code visible. The size is also small enough to cover same-edge load and select collisions, multi-register loads, and a clear asserted partway through a run.

// File: rtl/rf_pkg.sv
package rf_pkg;
  parameter int NUM_REGS = 4;
  parameter int DATA_W   = 4;
  localparam int SEL_W   = $clog2(NUM_REGS);

  typedef struct packed {
    logic [NUM_REGS-1:0] load;
    logic [NUM_REGS-1:0] pickA;
    logic [NUM_REGS-1:0] pickB;
  } rfStrobes_t;
endpackage

// File: rtl/rf_ctrl.sv
module rf_ctrl
  import rf_pkg::*;
(
  input  logic [NUM_REGS-1:0] wrEn,
  input  logic [SEL_W-1:0]    selA,
  input  logic [SEL_W-1:0]    selB,
  output rfStrobes_t          strobes
);
  logic [NUM_REGS-1:0] decA;
  logic [NUM_REGS-1:0] decB;

  // Decode each select code to a one-hot pick vector.
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_dec
    assign decA[r] = (selA == SEL_W'(r));
    assign decB[r] = (selB == SEL_W'(r));
  end

  always_comb begin
    strobes.load  = wrEn;
    strobes.pickA = decA;
    strobes.pickB = decB;
  end
endmodule

// File: rtl/rf_datapath.sv
module rf_datapath
  import rf_pkg::*;
(
  input  logic               clk,
  input  logic               clearN,
  input  rfStrobes_t         strobes,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  opndA,
  output logic [DATA_W-1:0]  opndB
);
  logic [DATA_W-1:0] gpr [NUM_REGS];
  logic [DATA_W-1:0] muxA;
  logic [DATA_W-1:0] muxB;

  // Storage: one register per entry, own load strobe, shared data.
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk or negedge clearN) begin
      if (!clearN)               gpr[r] <= '0;
      else if (strobes.load[r])  gpr[r] <= wrData;
    end
  end

  // Read selection: one AND-OR selector per bit column and side.
  for (genvar b = 0; b < DATA_W; b++) begin : g_col
    logic [NUM_REGS-1:0] colBits;
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_tap
      assign colBits[r] = gpr[r][b];
    end
    assign muxA[b] = |(colBits & strobes.pickA);
    assign muxB[b] = |(colBits & strobes.pickB);
  end

  // Operand capture registers.
  always_ff @(posedge clk or negedge clearN) begin
    if (!clearN) begin
      opndA <= '0;
      opndB <= '0;
    end else begin
      opndA <= muxA;
      opndB <= muxB;
    end
  end
endmodule

// File: rtl/opnd_regfile.sv
module opnd_regfile
  import rf_pkg::*;
(
  input  logic                clk,
  input  logic                clearN,
  input  logic [NUM_REGS-1:0] wrEn,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [SEL_W-1:0]    selA,
  input  logic [SEL_W-1:0]    selB,
  output logic [DATA_W-1:0]   opndA,
  output logic [DATA_W-1:0]   opndB
);
  rfStrobes_t strobes;

  rf_ctrl i_ctrl (
    .wrEn    (wrEn),
    .selA    (selA),
    .selB    (selB),
    .strobes (strobes)
  );

  rf_datapath i_dp (
    .clk     (clk),
    .clearN  (clearN),
    .strobes (strobes),
    .wrData  (wrData),
    .opndA   (opndA),
    .opndB   (opndB)
  );
endmodule

// File: rtl/opnd_regfile_chk.sv
module opnd_regfile_chk
  import rf_pkg::*;
(
  input logic                clk,
  input logic                clearN,
  input logic [NUM_REGS-1:0] wrEn,
  input logic [DATA_W-1:0]   wrData,
  input logic [SEL_W-1:0]    selA,
  input logic [SEL_W-1:0]    selB,
  input logic [DATA_W-1:0]   opndA,
  input logic [DATA_W-1:0]   opndB
);
  // Shadow of the register contents, built from the ports only.
  logic [DATA_W-1:0] shadow [NUM_REGS];
  logic [DATA_W-1:0] shadowA;
  logic [DATA_W-1:0] shadowB;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_sh
    always_ff @(posedge clk or negedge clearN) begin
      if (!clearN)      shadow[r] <= '0;
      else if (wrEn[r]) shadow[r] <= wrData;
    end
  end

  assign shadowA = shadow[selA];
  assign shadowB = shadow[selB];

  p_clear_zero_r1: assert property (@(posedge clk)
    !clearN |-> (opndA == '0 && opndB == '0));

  p_pick_a_r3: assert property (@(posedge clk) disable iff (!clearN)
    clearN |=> (opndA == $past(shadowA)));

  p_pick_b_r4: assert property (@(posedge clk) disable iff (!clearN)
    clearN |=> (opndB == $past(shadowB)));

  p_same_pick_r5: assert property (@(posedge clk) disable iff (!clearN)
    (selA == selB) |=> (opndA == opndB));

  p_old_data_r6: assert property (@(posedge clk) disable iff (!clearN)
    (wrEn[selA] && wrData != shadowA) |=> (opndA != $past(wrData)));
endmodule

bind opnd_regfile opnd_regfile_chk i_chk (.*);

// File: tb/test_opnd_regfile.sv
module test_opnd_regfile;
  import rf_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic                clk = 1'b0;
  logic                clearN = 1'b1;
  logic [NUM_REGS-1:0] wrEn = '0;
  logic [DATA_W-1:0]   wrData = '0;
  logic [SEL_W-1:0]    selA = '0;
  logic [SEL_W-1:0]    selB = '0;
  logic [DATA_W-1:0]   opndA;
  logic [DATA_W-1:0]   opndB;

  logic [DATA_W-1:0] mdl [NUM_REGS];
  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  opnd_regfile i_opnd_regfile (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Advance one rising edge and settle past it.
  task automatic cycle();
    @(posedge clk);
    #1;
  endtask

  task automatic load(logic [NUM_REGS-1:0] en, logic [DATA_W-1:0] d);
    wrEn = en; wrData = d;
    cycle();
    for (int r = 0; r < NUM_REGS; r++) if (en[r]) mdl[r] = d;
    wrEn = '0;
  endtask

  task automatic t_reset();
    #1 clearN = 1'b0;
    #1;
    check("R1 opndA at clear", opndA, '0);
    check("R1 opndB at clear", opndB, '0);
    cycle();
    clearN = 1'b1;
    for (int r = 0; r < NUM_REGS; r++) mdl[r] = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      selA = SEL_W'(r); cycle();
      check("R1 register zero after clear", opndA, '0);
    end
  endtask

  task automatic t_write_read();
    for (int r = 0; r < NUM_REGS; r++) load(NUM_REGS'(1) << r, DATA_W'(4'h9 + 3*r));
    for (int r = 0; r < NUM_REGS; r++) begin
      selA = SEL_W'(r); selB = SEL_W'(NUM_REGS-1-r);
      cycle();
      check("R3 selA code picks register", opndA, mdl[r]);
      check("R4 selB code picks register", opndB, mdl[NUM_REGS-1-r]);
    end
  endtask

  task automatic t_hold();
    load(4'b0010, 4'h5);
    selA = 2'd0; selB = 2'd2; cycle();
    check("R2 disabled R0 kept", opndA, mdl[0]);
    check("R2 disabled R2 kept", opndB, mdl[2]);
    selA = 2'd1; cycle();
    check("R2 enabled R1 loaded", opndA, 4'h5);
  endtask

  task automatic t_same_sel();
    selA = 2'd3; selB = 2'd3; cycle();
    check("R5 A same register", opndA, mdl[3]);
    check("R5 B same register", opndB, mdl[3]);
  endtask

  task automatic t_collision();
    logic [DATA_W-1:0] oldVal;
    oldVal = mdl[2];
    selA = 2'd2; selB = 2'd2;
    load(4'b0100, 4'hE);
    check("R6 A captures old contents", opndA, oldVal);
    check("R6 B captures old contents", opndB, oldVal);
    cycle();
    check("R6 new contents next edge", opndA, 4'hE);
  endtask

  task automatic t_multi_write();
    load(4'b1011, 4'h7);
    selA = 2'd0; selB = 2'd1; cycle();
    check("R8 R0 loaded", opndA, 4'h7);
    check("R8 R1 loaded", opndB, 4'h7);
    selA = 2'd3; selB = 2'd2; cycle();
    check("R8 R3 loaded", opndA, 4'h7);
    check("R8 R2 untouched", opndB, mdl[2]);
  endtask

  task automatic t_between_edges();
    load(4'b0001, 4'h1);
    selA = 2'd0; cycle();
    selA = 2'd2; selB = 2'd0;
    #2;
    check("R7 A holds between edges", opndA, 4'h1);
    cycle();
    check("R7 A updates at edge", opndA, mdl[2]);
  endtask

  task automatic t_mid_clear();
    @(negedge clk);
    clearN = 1'b0;
    #1;
    check("R1 async A clear", opndA, '0);
    check("R1 async B clear", opndB, '0);
    cycle();
    clearN = 1'b1;
    for (int r = 0; r < NUM_REGS; r++) mdl[r] = '0;
    selA = 2'd3; selB = 2'd1; cycle();
    check("R1 R3 cleared", opndA, '0);
    check("R1 R1 cleared", opndB, '0);
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_hold();
    t_same_sel();
    t_collision();
    t_multi_write();
    t_between_edges();
    t_mid_clear();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_PERIOD * 5000);
        nTests++; nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule